// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup Controller

This block holds the tag, valid and data storage of a small direct-mapped cache and runs the lookup sequence that makes it behave close to a two-way cache on conflicts. Every request first checks its home set, so the common hit costs no more than a plain direct-mapped hit. When the home set misses, a second check is made in the partner set, whose index differs from the home index only in its top bit. Only when both checks miss is the next memory level asked for the word.

A read that hits in the partner set is swapped back into its home set, so the block used last is the fast one next time. A read miss fills the home set, and the block pushed out of the home set moves into the partner set. Writes go straight through to memory. A write that hits updates the cached word where it was found; a write that misses leaves the cache unchanged. One request is handled at a time. Each block is one word wide.

Top module: `pseudo_assoc_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, every set is empty, req_ready_o is 1, rsp_valid_o is 0 and mem_req_o is 0; a read of an address cached before a reset misses after it.
- R2: A read found in its home set (index = low IDX_W address bits) gives rsp_valid_o one cycle after the accepting edge, with rsp_hit_o = 2'b01, the cached word and no memory request.
- R3: A read missing at home but found in the partner set (home index with its top bit inverted) gives rsp_valid_o two cycles after acceptance, with rsp_hit_o = 2'b10, the cached word and no memory request.
- R4: A read hit in the partner set swaps the two sets, so the same address then gives a 2'b01 hit and the block that was at home moves to the partner set.
- R5: A read missing in both sets issues exactly one memory read at the request address; the response carries rsp_hit_o = 2'b00 and the memory word one cycle after mem_ack_i.
- R6: On a read miss the new word fills the home set, the previous home content moves to the partner set, and the previous partner content is dropped.
- R7: The stored tag is the address above the index plus the top index bit, so a block held in a set that is not its home never answers for another address with the same upper bits.
- R8: Every write issues one memory write of mem_addr_o = request address and mem_wdata_o = write data; the response follows mem_ack_i by one cycle with rsp_data_o = write data and rsp_hit_o giving where it was found (01 home, 10 partner, 00 absent).
- R9: A write hit updates the cached word in place without moving blocks; a write miss allocates nothing.
- R10: req_ready_o is 1 only when no request is in progress; it is 0 in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_data_o | output | DATA_W | Read word, or write data for writes |
| rsp_hit_o | output | 2 | 00 miss, 01 home hit, 10 partner hit |
| mem_req_o | output | 1 | Next-level access requested, held until ack |
| mem_we_o | output | 1 | Next-level access is a write |
| mem_addr_o | output | ADDR_W | Next-level word address |
| mem_wdata_o | output | DATA_W | Next-level write data |
| mem_ack_i | input | 1 | Next level done; read data valid |
| mem_rdata_i | input | DATA_W | Next-level read data |

## Verification
The bench uses the defaults ADDR_W = 8, IDX_W = 3 and DATA_W = 16, so there are eight sets and the partner of set n is set n xor 4. With so few sets, a handful of addresses such as 0x10, 0x20, 0x14 and 0x24 fight over sets 0 and 4. This exercises swaps, evictions into the partner set, loss of the old partner block and the tag bit that tells home-resident blocks from partner-resident ones. The 0x07/0x0B pair checks the same rules at the top set pair, 3 and 7.

// File: rtl/pa_pkg.sv
`timescale 1ns/1ps
package pa_pkg;
  typedef enum logic [1:0] {
    HIT_MISS   = 2'b00,
    HIT_FAST   = 2'b01,
    HIT_PSEUDO = 2'b10
  } hit_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_P1,
    ST_P2,
    ST_MEM
  } st_e;
endpackage

// File: rtl/pa_store.sv
`timescale 1ns/1ps
module pa_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_p_i,
  input  logic              wr_p_en_i,
  input  logic              wr_p_vld_i,
  input  logic [TAG_W-1:0]  wr_p_tag_i,
  input  logic [DATA_W-1:0] wr_p_data_i,
  input  logic              wr_a_en_i,
  input  logic              wr_a_vld_i,
  input  logic [TAG_W-1:0]  wr_a_tag_i,
  input  logic [DATA_W-1:0] wr_a_data_i,
  output logic              rd_p_vld_o,
  output logic [TAG_W-1:0]  rd_p_tag_o,
  output logic [DATA_W-1:0] rd_p_data_o,
  output logic              rd_a_vld_o,
  output logic [TAG_W-1:0]  rd_a_tag_o,
  output logic [DATA_W-1:0] rd_a_data_o
);
  localparam int SETS = 1 << IDX_W;
  localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

  logic              vld_q  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];
  logic [IDX_W-1:0]  idx_a;

  assign idx_a = idx_p_i ^ FLIP;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic sel_p, sel_a;
    assign sel_p = wr_p_en_i && (idx_p_i == IDX_W'(g));
    assign sel_a = wr_a_en_i && (idx_a == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_q[g] <= 1'b0;
      else if (sel_p) vld_q[g] <= wr_p_vld_i;
      else if (sel_a) vld_q[g] <= wr_a_vld_i;
    end

    always_ff @(posedge clk_i) begin
      if (sel_p) begin
        tag_q[g]  <= wr_p_tag_i;
        data_q[g] <= wr_p_data_i;
      end else if (sel_a) begin
        tag_q[g]  <= wr_a_tag_i;
        data_q[g] <= wr_a_data_i;
      end
    end
  end

  assign rd_p_vld_o  = vld_q[idx_p_i];
  assign rd_p_tag_o  = tag_q[idx_p_i];
  assign rd_p_data_o = data_q[idx_p_i];
  assign rd_a_vld_o  = vld_q[idx_a];
  assign rd_a_tag_o  = tag_q[idx_a];
  assign rd_a_data_o = data_q[idx_a];
endmodule

// File: rtl/pa_probe.sv
`timescale 1ns/1ps
module pa_probe #(
  parameter int TAG_W = 6
) (
  input  logic             vld_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] want_i,
  output logic             hit_o
);
  assign hit_o = vld_i && (tag_i == want_i);
endmodule

// File: rtl/pa_ctrl.sv
`timescale 1ns/1ps
module pa_ctrl
  import pa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [1:0]        rsp_hit_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o,
  input  logic              hit_p_i,
  input  logic              hit_a_i,
  input  logic              rd_p_vld_i,
  input  logic [TAG_W-1:0]  rd_p_tag_i,
  input  logic [DATA_W-1:0] rd_p_data_i,
  input  logic              rd_a_vld_i,
  input  logic [TAG_W-1:0]  rd_a_tag_i,
  input  logic [DATA_W-1:0] rd_a_data_i,
  output logic              wr_p_en_o,
  output logic              wr_p_vld_o,
  output logic [TAG_W-1:0]  wr_p_tag_o,
  output logic [DATA_W-1:0] wr_p_data_o,
  output logic              wr_a_en_o,
  output logic              wr_a_vld_o,
  output logic [TAG_W-1:0]  wr_a_tag_o,
  output logic [DATA_W-1:0] wr_a_data_o
);
  st_e               st_q, st_d;
  hit_e              where_q, where_d, hit_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, data_d;
  logic              we_q, fire;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  hit_e              rsp_hit_q;

  assign req_ready_o = (st_q == ST_IDLE);
  assign idx_o       = addr_q[IDX_W-1:0];
  assign tag_o       = addr_q[ADDR_W-1:IDX_W-1];
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign rsp_hit_o   = rsp_hit_q;

  always_comb begin
    st_d        = st_q;
    where_d     = where_q;
    fire        = 1'b0;
    data_d      = '0;
    hit_d       = HIT_MISS;
    mem_req_o   = 1'b0;
    wr_p_en_o   = 1'b0;
    wr_p_vld_o  = rd_p_vld_i;
    wr_p_tag_o  = rd_p_tag_i;
    wr_p_data_o = rd_p_data_i;
    wr_a_en_o   = 1'b0;
    wr_a_vld_o  = rd_a_vld_i;
    wr_a_tag_o  = rd_a_tag_i;
    wr_a_data_o = rd_a_data_i;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_P1;
      ST_P1: begin
        if (!hit_p_i) st_d = ST_P2;
        else if (we_q) begin
          wr_p_en_o   = 1'b1;
          wr_p_data_o = wdata_q;
          where_d     = HIT_FAST;
          st_d        = ST_MEM;
        end else begin
          fire   = 1'b1;
          data_d = rd_p_data_i;
          hit_d  = HIT_FAST;
          st_d   = ST_IDLE;
        end
      end
      ST_P2: begin
        if (!hit_a_i) begin
          where_d = HIT_MISS;
          st_d    = ST_MEM;
        end else if (we_q) begin
          wr_a_en_o   = 1'b1;
          wr_a_data_o = wdata_q;
          where_d     = HIT_PSEUDO;
          st_d        = ST_MEM;
        end else begin
          // swap: last used block returns home
          fire        = 1'b1;
          data_d      = rd_a_data_i;
          hit_d       = HIT_PSEUDO;
          wr_p_en_o   = 1'b1;
          wr_p_vld_o  = rd_a_vld_i;
          wr_p_tag_o  = rd_a_tag_i;
          wr_p_data_o = rd_a_data_i;
          wr_a_en_o   = 1'b1;
          wr_a_vld_o  = rd_p_vld_i;
          wr_a_tag_o  = rd_p_tag_i;
          wr_a_data_o = rd_p_data_i;
          st_d        = ST_IDLE;
        end
      end
      ST_MEM: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          fire   = 1'b1;
          data_d = we_q ? wdata_q : mem_rdata_i;
          hit_d  = where_q;
          st_d   = ST_IDLE;
          if (!we_q) begin
            // refill home, displaced block to partner
            wr_p_en_o   = 1'b1;
            wr_p_vld_o  = 1'b1;
            wr_p_tag_o  = tag_o;
            wr_p_data_o = mem_rdata_i;
            wr_a_en_o   = 1'b1;
            wr_a_vld_o  = rd_p_vld_i;
            wr_a_tag_o  = rd_p_tag_i;
            wr_a_data_o = rd_p_data_i;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      where_q     <= HIT_MISS;
      addr_q      <= '0;
      wdata_q     <= '0;
      we_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_hit_q   <= HIT_MISS;
    end else begin
      st_q        <= st_d;
      where_q     <= where_d;
      rsp_valid_q <= fire;
      if (fire) begin
        rsp_data_q <= data_d;
        rsp_hit_q  <= hit_d;
      end
      if (req_valid_i && req_ready_o) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        we_q    <= req_we_i;
      end
    end
  end

  AST_FAST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_P1 && hit_p_i && !we_q) |=> (rsp_valid_o && rsp_hit_o == 2'b01)); // R2
  AST_PSEUDO_TWO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_P2 && hit_a_i && !we_q) |=> (rsp_valid_o && rsp_hit_o == 2'b10)); // R3
  AST_SWAP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_P2 && hit_a_i && !we_q) |=>
      ({rd_p_vld_i, rd_p_tag_i, rd_p_data_i} == $past({rd_a_vld_i, rd_a_tag_i, rd_a_data_i}) &&
       {rd_a_vld_i, rd_a_tag_i, rd_a_data_i} == $past({rd_p_vld_i, rd_p_tag_i, rd_p_data_i}))); // R4
  AST_ACK_TO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> rsp_valid_o); // R5
  AST_REFILL_PLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !we_q) |=>
      (rd_p_vld_i && rd_p_data_i == $past(mem_rdata_i) &&
       {rd_a_vld_i, rd_a_tag_i, rd_a_data_i} == $past({rd_p_vld_i, rd_p_tag_i, rd_p_data_i}))); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R10
endmodule

// File: rtl/pseudo_assoc_ctrl.sv
`timescale 1ns/1ps
module pseudo_assoc_ctrl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [1:0]        rsp_hit_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int TAG_W = ADDR_W - IDX_W + 1;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit_p, hit_a;
  logic              rd_p_vld, rd_a_vld, wr_p_en, wr_a_en, wr_p_vld, wr_a_vld;
  logic [TAG_W-1:0]  rd_p_tag, rd_a_tag, wr_p_tag, wr_a_tag;
  logic [DATA_W-1:0] rd_p_data, rd_a_data, wr_p_data, wr_a_data;

  pa_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_we_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_data_o, .rsp_hit_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .idx_o(idx), .tag_o(tag), .hit_p_i(hit_p), .hit_a_i(hit_a),
    .rd_p_vld_i(rd_p_vld), .rd_p_tag_i(rd_p_tag), .rd_p_data_i(rd_p_data),
    .rd_a_vld_i(rd_a_vld), .rd_a_tag_i(rd_a_tag), .rd_a_data_i(rd_a_data),
    .wr_p_en_o(wr_p_en), .wr_p_vld_o(wr_p_vld), .wr_p_tag_o(wr_p_tag), .wr_p_data_o(wr_p_data),
    .wr_a_en_o(wr_a_en), .wr_a_vld_o(wr_a_vld), .wr_a_tag_o(wr_a_tag), .wr_a_data_o(wr_a_data)
  );

  pa_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .idx_p_i(idx),
    .wr_p_en_i(wr_p_en), .wr_p_vld_i(wr_p_vld), .wr_p_tag_i(wr_p_tag), .wr_p_data_i(wr_p_data),
    .wr_a_en_i(wr_a_en), .wr_a_vld_i(wr_a_vld), .wr_a_tag_i(wr_a_tag), .wr_a_data_i(wr_a_data),
    .rd_p_vld_o(rd_p_vld), .rd_p_tag_o(rd_p_tag), .rd_p_data_o(rd_p_data),
    .rd_a_vld_o(rd_a_vld), .rd_a_tag_o(rd_a_tag), .rd_a_data_o(rd_a_data)
  );

  // home and partner compare; tag carries top index bit (R7)
  pa_probe #(.TAG_W(TAG_W)) u_probe_p (.vld_i(rd_p_vld), .tag_i(rd_p_tag), .want_i(tag), .hit_o(hit_p));
  pa_probe #(.TAG_W(TAG_W)) u_probe_a (.vld_i(rd_a_vld), .tag_i(rd_a_tag), .want_i(tag), .hit_o(hit_a));

  AST_NO_DOUBLE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_p && hit_a)); // R7
endmodule

// File: tb/sim_pseudo_assoc_ctrl.sv
`timescale 1ns/1ps
module sim_pseudo_assoc_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, mem_req, mem_we;
  logic [15:0] rsp_data, mem_wdata;
  logic [1:0]  rsp_hit;
  logic [7:0]  mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] tb_mem [256];
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pseudo_assoc_ctrl #(.ADDR_W(8), .IDX_W(3), .DATA_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_hit_o(rsp_hit),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [1:0]  hit;
    logic [15:0] data;
    logic [1:0]  lat;
    logic [3:0]  req;
  } vec_t;

  // set n partner = n^4; memory starts as 16'h5A00|addr
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    {1'b0, 8'h10, 16'h0000, 2'b00, 16'h5A10, 2'd3, 4'd5},  // R5 cold miss
    {1'b0, 8'h10, 16'h0000, 2'b01, 16'h5A10, 2'd1, 4'd2},  // R2
    {1'b0, 8'h20, 16'h0000, 2'b00, 16'h5A20, 2'd3, 4'd5},  // 10 pushed to set 4
    {1'b0, 8'h10, 16'h0000, 2'b10, 16'h5A10, 2'd2, 4'd3},  // R3
    {1'b0, 8'h10, 16'h0000, 2'b01, 16'h5A10, 2'd1, 4'd4},  // R4 swapped home
    {1'b0, 8'h20, 16'h0000, 2'b10, 16'h5A20, 2'd2, 4'd3},
    {1'b0, 8'h24, 16'h0000, 2'b00, 16'h5A24, 2'd3, 4'd5},  // 10 displaced into set 0
    {1'b0, 8'h10, 16'h0000, 2'b01, 16'h5A10, 2'd1, 4'd6},  // R6 displaced block kept
    {1'b0, 8'h20, 16'h0000, 2'b00, 16'h5A20, 2'd3, 4'd6},  // R6 old partner dropped
    {1'b0, 8'h14, 16'h0000, 2'b00, 16'h5A14, 2'd3, 4'd7},  // R7 10 in set 4 must not match
    {1'b0, 8'h10, 16'h0000, 2'b01, 16'h5A10, 2'd1, 4'd6},
    {1'b0, 8'h14, 16'h0000, 2'b01, 16'h5A14, 2'd1, 4'd7},
    {1'b1, 8'h14, 16'h1234, 2'b01, 16'h1234, 2'd2, 4'd8},  // R8 write home hit
    {1'b0, 8'h14, 16'h0000, 2'b01, 16'h1234, 2'd1, 4'd9},  // R9 updated in place
    {1'b0, 8'h30, 16'h0000, 2'b00, 16'h5A30, 2'd3, 4'd5},  // 10 to set 4
    {1'b1, 8'h10, 16'hBEEF, 2'b10, 16'hBEEF, 2'd3, 4'd8},  // write partner hit
    {1'b0, 8'h10, 16'h0000, 2'b10, 16'hBEEF, 2'd2, 4'd9},  // R9 write did not swap
    {1'b0, 8'h10, 16'h0000, 2'b01, 16'hBEEF, 2'd1, 4'd4},
    {1'b1, 8'h11, 16'h7777, 2'b00, 16'h7777, 2'd3, 4'd8},  // write miss
    {1'b0, 8'h11, 16'h0000, 2'b00, 16'h7777, 2'd3, 4'd9},  // R9 no allocate, R8 through
    {1'b0, 8'h11, 16'h0000, 2'b01, 16'h7777, 2'd1, 4'd2},
    {1'b0, 8'h07, 16'h0000, 2'b00, 16'h5A07, 2'd3, 4'd5},
    {1'b0, 8'h0B, 16'h0000, 2'b00, 16'h5A0B, 2'd3, 4'd6},  // empty home pushed over set 7
    {1'b0, 8'h07, 16'h0000, 2'b00, 16'h5A07, 2'd3, 4'd6}
  };

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s got %h exp %h", rq, what, got, exp);
    end
  endtask

  task automatic run(input logic we, input logic [7:0] addr, input logic [15:0] wdata,
                     output logic [1:0] hit, output logic [15:0] data, output int lat,
                     output int nrd, output int nwr, output logic [7:0] maddr,
                     output logic busy_ready);
    int n;
    nrd = 0; nwr = 0; maddr = '0; hit = '0; data = '0; lat = 99;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ready = req_ready;
    n = 1;
    while (1) begin
      if (mem_ack) mem_ack = 1'b0;
      if (rsp_valid) begin
        hit = rsp_hit; data = rsp_data; lat = n - 1;
        break;
      end
      if (mem_req) begin
        mem_ack = 1'b1;
        maddr = mem_addr;
        mem_rdata = tb_mem[mem_addr];
        if (mem_we) begin
          tb_mem[mem_addr] = mem_wdata;
          nwr++;
        end else nrd++;
      end
      if (n > 40) begin
        check(1'b0, 10, "request timeout", 16'(n), 16'd40);
        break;
      end
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #500us;
    n_bad++;
    $display("FAIL R10 watchdog expired got %0d exp %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [1:0]  hit;
    logic [15:0] data;
    logic [7:0]  maddr;
    logic        bready;
    int          lat, nrd, nwr;
    for (int a = 0; a < 256; a++) tb_mem[a] = 16'h5A00 | 16'(a);

    // R1 reset state
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, 1, "ready in reset", 16'(req_ready), 16'd1);
    check(rsp_valid == 1'b0, 1, "rsp_valid in reset", 16'(rsp_valid), 16'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(mem_req == 1'b0, 1, "mem_req after reset", 16'(mem_req), 16'd0);
    check(req_ready == 1'b1, 1, "ready after reset", 16'(req_ready), 16'd1);

    for (int i = 0; i < NV; i++) begin
      int rq;
      int exp_rd, exp_wr;
      rq = int'(VEC[i].req);
      run(VEC[i].we, VEC[i].addr, VEC[i].wdata, hit, data, lat, nrd, nwr, maddr, bready);
      exp_rd = (!VEC[i].we && VEC[i].hit == 2'b00) ? 1 : 0;
      exp_wr = VEC[i].we ? 1 : 0;
      check(hit == VEC[i].hit, rq, $sformatf("vec %0d hit code", i), 16'(hit), 16'(VEC[i].hit));
      check(data == VEC[i].data, rq, $sformatf("vec %0d data", i), data, VEC[i].data);
      check(lat == int'(VEC[i].lat), rq, $sformatf("vec %0d latency", i), 16'(lat), 16'(VEC[i].lat));
      check(nrd == exp_rd && nwr == exp_wr, rq, $sformatf("vec %0d mem rd/wr count", i),
            16'(nrd * 16 + nwr), 16'(exp_rd * 16 + exp_wr));
      if (exp_rd + exp_wr != 0)
        check(maddr == VEC[i].addr, rq, $sformatf("vec %0d mem addr", i), 16'(maddr), 16'(VEC[i].addr));
      check(bready == 1'b0, 10, $sformatf("vec %0d ready while busy", i), 16'(bready), 16'd0);
    end

    // R1 reset empties the sets: 0x10 was a home hit
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b0 && mem_req == 1'b0, 1, "outputs in mid-run reset",
          16'({rsp_valid, mem_req}), 16'd0);
    rst_ni = 1'b1;
    run(1'b0, 8'h10, 16'h0000, hit, data, lat, nrd, nwr, maddr, bready);
    check(hit == 2'b00, 1, "hit after reset", 16'(hit), 16'd0);
    check(data == 16'hBEEF && nrd == 1, 1, "refetched data", data, 16'hBEEF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule